// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs the bus side of a NAND flash controller from a small register set. Software loads a column offset, a page number and two buffer base addresses, then writes one 32-bit command word. That word holds the opcode, a mask that selects which address bytes are sent, a set of phase flags and a byte count. From this word the sequencer produces every operation: reset, ID and status reads, page reads, page programs and block erases.

Each operation runs in a fixed order. First comes an opcode latch cycle with CLE high. Next, each selected address byte gets one latch cycle with ALE high. The engine can then wait for the ready/busy line to return high. Last, it moves the programmed number of bytes between the flash and an internal byte-wide buffer port. Bit 31 of the command word reads as busy for as long as the operation runs. A one-cycle interrupt pulse can mark the end of the operation. Software writes the pattern 0x7FFFFFFF to the command register to abandon whatever is running and return the sequencer to idle.

Top module: `nand_seq_core`

## Requirements
- R1: After reset, bit 31 of the command register reads 0, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, and `irq` is 0.
- R2: When the block is idle, a command-register write with bit 31 set starts an operation. The opcode in bits 23:16 is sent first, in one `nand_we_n` strobe with `nand_cle` high. Bit 31 reads 1 from the cycle after the write until the operation completes, and `nand_ce_n` is low over exactly the same span.
- R3: Bits 28:24 form the address mask. Each set bit produces one `nand_we_n` strobe with `nand_ale` high, in increasing bit order after the opcode. Bit 0 sends column[7:0], bit 1 sends column[15:8], and bits 2, 3 and 4 send page[7:0], page[15:8] and page[23:16].
- R4: Every strobe holds its line low for STROBE_LO clocks and then high for STROBE_HI clocks. `nand_cle`, `nand_ale` and `nand_dq_out` stay constant while the strobe is low, and `nand_we_n` and `nand_re_n` are never low together.
- R5: With flag bit 15 set, no data strobe is issued until `nand_rb` reads 1. With bit 15 clear, `nand_rb` has no effect.
- R6: If flag bit 14 is clear, the data phase reads from the flash. It issues bits 11:0 `nand_re_n` strobes. Each byte is sampled in the last low cycle of its strobe and is written to the buffer at data base + byte index.
- R7: If flag bit 14 is set and bit 13 is clear, the data phase writes to the flash. Byte i is read from data base + i and driven on `nand_dq_out` during its `nand_we_n` strobe. No `nand_re_n` strobe occurs.
- R8: With flag bit 12 set, byte index i ≥ PAGE_BYTES goes to spare base + (i − PAGE_BYTES). With bit 12 clear, every byte goes to data base + i.
- R9: A byte count of 0 skips the data phase. Bit 31 then clears after the last address strobe, or after the ready wait if bit 15 is set.
- R10: If bit 30 is set, completion raises `irq` for exactly one clock, in the first cycle that bit 31 reads 0. If bit 30 is clear, completion produces no pulse.
- R11: A command-register write made while busy changes nothing, unless the value is 0x7FFFFFFF. That value ends the operation: in the next cycle bit 31 reads 0 and `nand_ce_n` is 1. No interrupt is raised and no further strobes follow.
- R12: Register 1 (column, 16 bits), register 2 (page, 24 bits), register 3 (data base) and register 4 (spare base) read back what was written. Register 0 reads the last accepted command word, with bit 31 showing busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 command, 1 column, 2 page, 3 data base, 4 spare base) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Chip enable, low while an operation runs |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe |
| nand_re_n | output | 1 | Read strobe |
| nand_dq_out | output | 8 | Byte driven to the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Byte returned by the flash |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |
| buf_addr | output | BUF_AW | Buffer byte address |
| buf_wr | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer read byte for `buf_addr`, combinational |

## Verification
The bench builds the core with PAGE_BYTES = 16, BUF_AW = 8, STROBE_LO = 2 and STROBE_HI = 1. A 16-byte page means a 20-byte transfer crosses into the spare area, so the split and the contiguous routing can both be checked in a few dozen cycles rather than thousands. Making the low time differ from the high time lets a strobe-width check detect a swapped or miscounted phase. An 8-bit buffer address keeps both base pointers and their offsets inside a 256-byte model memory.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    // Layout of the command register
    typedef struct packed {
        logic        busy;        // 31
        logic        irq_en;      // 30
        logic        rsv;         // 29
        logic [4:0]  amask;       // 28:24
        logic [7:0]  opcode;      // 23:16
        logic        wait_rdy;    // 15
        logic        to_nand;     // 14
        logic        from_nand;   // 13
        logic        spare_split; // 12
        logic [11:0] nbytes;      // 11:0
    } nand_cmd_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADR,
        PH_RDY,
        PH_XFER
    } phase_e;

    localparam logic [31:0] CLEAR_WORD = 32'h7FFF_FFFF;

    localparam logic [2:0] RA_CMD   = 3'd0;
    localparam logic [2:0] RA_COL   = 3'd1;
    localparam logic [2:0] RA_ROW   = 3'd2;
    localparam logic [2:0] RA_DBASE = 3'd3;
    localparam logic [2:0] RA_SBASE = 3'd4;

    // Index of the lowest set bit of an address mask
    function automatic logic [2:0] lowest_set(input logic [4:0] m);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 4; i >= 0; i--) begin
            if (m[i]) r = 3'(i);
        end
        return r;
    endfunction

    // Phase that follows the opcode or an address byte
    function automatic phase_e after_addr(input logic [4:0] rem, input logic wt,
                                          input logic [11:0] n);
        if (rem != 5'd0)     return PH_ADR;
        else if (wt)         return PH_RDY;
        else if (n != 12'd0) return PH_XFER;
        else                 return PH_IDLE;
    endfunction

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int BUF_AW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              done,
    output nand_cmd_t         cmd,
    output logic              start,
    output logic              abort,
    output logic [15:0]       col,
    output logic [23:0]       row,
    output logic [BUF_AW-1:0] dbase,
    output logic [BUF_AW-1:0] sbase,
    output logic [31:0]       rdata
);
    logic hit_cmd;

    assign hit_cmd = wr_en && (addr == RA_CMD);
    assign abort   = hit_cmd && (wdata == CLEAR_WORD);
    assign start   = hit_cmd && !cmd.busy && wdata[31];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd   <= '0;
            col   <= '0;
            row   <= '0;
            dbase <= '0;
            sbase <= '0;
        end else begin
            if (abort)                   cmd      <= nand_cmd_t'(wdata);
            else if (done)               cmd.busy <= 1'b0;
            else if (hit_cmd && !cmd.busy) cmd    <= nand_cmd_t'(wdata);
            if (wr_en && addr == RA_COL)   col   <= wdata[15:0];
            if (wr_en && addr == RA_ROW)   row   <= wdata[23:0];
            if (wr_en && addr == RA_DBASE) dbase <= wdata[BUF_AW-1:0];
            if (wr_en && addr == RA_SBASE) sbase <= wdata[BUF_AW-1:0];
        end
    end

    always_comb begin
        unique case (addr)
            RA_CMD:   rdata = cmd;
            RA_COL:   rdata = {16'd0, col};
            RA_ROW:   rdata = {8'd0, row};
            RA_DBASE: rdata = 32'(dbase);
            RA_SBASE: rdata = 32'(sbase);
            default:  rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
    parameter int STROBE_LO = 1,
    parameter int STROBE_HI = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic low,
    output logic cap,
    output logic last
);
    localparam int TW = $clog2(STROBE_LO + STROBE_HI);
    localparam logic [TW-1:0] LO_V  = TW'(STROBE_LO);
    localparam logic [TW-1:0] CAP_V = TW'(STROBE_LO - 1);
    localparam logic [TW-1:0] END_V = TW'(STROBE_LO + STROBE_HI - 1);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || !run)   tcnt <= '0;
        else if (last)     tcnt <= '0;
        else               tcnt <= tcnt + 1'b1;
    end

    assign low  = run && (tcnt < LO_V);
    assign cap  = run && (tcnt == CAP_V);
    assign last = run && (tcnt == END_V);
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int BUF_AW     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [4:0]        start_mask,
    input  logic [7:0]        opcode,
    input  logic              wait_rdy,
    input  logic              to_nand,
    input  logic              from_nand,
    input  logic              spare_split,
    input  logic [11:0]       nbytes,
    input  logic [15:0]       col,
    input  logic [23:0]       row,
    input  logic [BUF_AW-1:0] dbase,
    input  logic [BUF_AW-1:0] sbase,
    input  logic              rb,
    input  logic [7:0]        dq_in,
    input  logic [7:0]        buf_rdata,
    input  logic              st_low,
    input  logic              st_cap,
    input  logic              st_last,
    output logic              run,
    output logic              done,
    output logic              ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              buf_wr,
    output logic [7:0]        buf_wdata
);
    localparam logic [11:0] PAGE_B = 12'(PAGE_BYTES);

    phase_e      ph, ph_nx;
    logic [4:0]  rem, rem_nx;
    logic [11:0] idx;
    logic [2:0]  cur;
    logic        last_byte, wr_dir, drive, in_spare;
    logic [7:0]  abyte;

    always_comb begin
        cur       = lowest_set(rem);
        rem_nx    = (ph == PH_ADR) ? (rem & ~(5'd1 << cur)) : rem;
        last_byte = (idx == nbytes - 12'd1);
        ph_nx     = ph;
        unique case (ph)
            PH_OPC, PH_ADR: if (st_last) ph_nx = after_addr(rem_nx, wait_rdy, nbytes);
            PH_RDY:         if (rb) ph_nx = (nbytes != 12'd0) ? PH_XFER : PH_IDLE;
            PH_XFER:        if (st_last && last_byte) ph_nx = PH_IDLE;
            default:        ph_nx = PH_IDLE;
        endcase
        done = (ph != PH_IDLE) && (ph_nx == PH_IDLE) && !abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            rem <= '0;
            idx <= '0;
        end else if (abort) begin
            ph <= PH_IDLE;
        end else if (start) begin
            ph  <= PH_OPC;
            rem <= start_mask;
            idx <= '0;
        end else begin
            ph <= ph_nx;
            if (ph == PH_ADR && st_last)  rem <= rem_nx;
            if (ph == PH_XFER && st_last) idx <= idx + 12'd1;
        end
    end

    always_comb begin
        unique case (cur)
            3'd0:    abyte = col[7:0];
            3'd1:    abyte = col[15:8];
            3'd2:    abyte = row[7:0];
            3'd3:    abyte = row[15:8];
            default: abyte = row[23:16];
        endcase
    end

    assign wr_dir   = to_nand && !from_nand;
    assign run      = (ph == PH_OPC) || (ph == PH_ADR) || (ph == PH_XFER);
    assign drive    = (ph == PH_OPC) || (ph == PH_ADR) || (ph == PH_XFER && wr_dir);
    assign ce_n     = (ph == PH_IDLE);
    assign cle      = (ph == PH_OPC);
    assign ale      = (ph == PH_ADR);
    assign we_n     = !(st_low && drive);
    assign re_n     = !(st_low && ph == PH_XFER && !wr_dir);
    assign dq_oe    = drive;
    assign dq_out   = (ph == PH_OPC) ? opcode :
                      (ph == PH_ADR) ? abyte  :
                      drive          ? buf_rdata : 8'd0;
    assign in_spare = spare_split && (idx >= PAGE_B);
    assign buf_addr = in_spare ? sbase + BUF_AW'(idx - PAGE_B) : dbase + BUF_AW'(idx);
    assign buf_wr   = (ph == PH_XFER) && !wr_dir && st_cap;
    assign buf_wdata = dq_in;
endmodule

// File: rtl/nand_seq_core.sv
module nand_seq_core
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int BUF_AW     = 12,
    parameter int STROBE_LO  = 1,
    parameter int STROBE_HI  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_in,
    input  logic              nand_rb,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              buf_wr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    nand_cmd_t         cmd;
    logic              start, abort, done, busy;
    logic [15:0]       col;
    logic [23:0]       row;
    logic [BUF_AW-1:0] dbase, sbase;
    logic              run, st_low, st_cap, st_last;
    nand_cmd_t         start_word;

    assign start_word = nand_cmd_t'(reg_wdata);
    assign busy       = cmd.busy;

    nand_seq_regs #(.BUF_AW(BUF_AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .done(done), .cmd(cmd), .start(start), .abort(abort), .col(col), .row(row),
        .dbase(dbase), .sbase(sbase), .rdata(reg_rdata)
    );

    nand_seq_strobe #(.STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI)) u_strobe (
        .clk(clk), .rst(rst), .run(run), .low(st_low), .cap(st_cap), .last(st_last)
    );

    nand_seq_fsm #(.PAGE_BYTES(PAGE_BYTES), .BUF_AW(BUF_AW)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .start_mask(start_word.amask),
        .opcode(cmd.opcode), .wait_rdy(cmd.wait_rdy), .to_nand(cmd.to_nand),
        .from_nand(cmd.from_nand), .spare_split(cmd.spare_split), .nbytes(cmd.nbytes),
        .col(col), .row(row), .dbase(dbase), .sbase(sbase), .rb(nand_rb),
        .dq_in(nand_dq_in), .buf_rdata(buf_rdata), .st_low(st_low), .st_cap(st_cap),
        .st_last(st_last), .run(run), .done(done), .ce_n(nand_ce_n), .cle(nand_cle),
        .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out),
        .dq_oe(nand_dq_oe), .buf_addr(buf_addr), .buf_wr(buf_wr), .buf_wdata(buf_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= done && cmd.irq_en;
    end
endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        irq,
    input logic        nand_ce_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic        nand_dq_oe,
    input logic        buf_wr,
    input logic        reg_wr_en,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata
);
    a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        nand_ce_n |-> (nand_we_n && nand_re_n && !nand_dq_oe && !nand_cle && !nand_ale));

    a_r2_ce_tracks_busy: assert property (@(posedge clk) disable iff (rst)
        busy == !nand_ce_n);

    a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    a_r6_capture_in_read_strobe: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> !nand_re_n);

    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r10_irq_at_completion: assert property (@(posedge clk) disable iff (rst)
        irq |-> $fell(busy));

    a_r11_abort_idles: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 3'd0 && reg_wdata == 32'h7FFF_FFFF) |=> (!busy && nand_ce_n && !irq));
endmodule

bind nand_seq_core nand_seq_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .irq(irq), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe), .buf_wr(buf_wr),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/nand_seq_core_test.sv
module nand_seq_core_test;
    localparam int PB = 16;
    localparam int AW = 8;
    localparam int LO = 2;
    localparam int HI = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [31:0]   reg_wdata = 32'd0;
    logic [31:0]   reg_rdata;
    logic          irq, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]    nand_dq_out;
    logic [7:0]    nand_dq_in = 8'h5A;
    logic          nand_rb = 1'b1;
    logic [AW-1:0] buf_addr;
    logic          buf_wr;
    logic [7:0]    buf_wdata, buf_rdata;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    nand_seq_core #(.PAGE_BYTES(PB), .BUF_AW(AW), .STROBE_LO(LO), .STROBE_HI(HI)) uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .buf_addr(buf_addr), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    // Buffer model: combinational read, clocked write
    logic [7:0] mem [0:255];
    assign buf_rdata = mem[buf_addr];
    always @(posedge clk) if (buf_wr) mem[buf_addr] <= buf_wdata;

    // Flash-side monitor, sampled at the falling clock edge
    int         n_lat = 0, n_rd = 0, irq_cnt = 0;
    int         width_bad = 0, stable_bad = 0, irq_busy_bad = 0;
    int         we_w = 0, re_w = 0;
    logic       prev_we = 1'b1, prev_re = 1'b1;
    logic [7:0] hold_dq;
    logic       hold_cle, hold_ale;
    logic [7:0] lat_val  [0:255];
    logic [1:0] lat_kind [0:255];

    always @(negedge clk) begin
        if (!nand_we_n) begin
            if (prev_we) begin
                hold_dq = nand_dq_out; hold_cle = nand_cle; hold_ale = nand_ale; we_w = 1;
            end else begin
                we_w++;
                if (nand_dq_out != hold_dq || nand_cle != hold_cle || nand_ale != hold_ale)
                    stable_bad++;
            end
        end else if (!prev_we) begin
            if (n_lat < 256) begin
                lat_val[n_lat]  = hold_dq;
                lat_kind[n_lat] = hold_cle ? 2'd1 : (hold_ale ? 2'd2 : 2'd0);
            end
            n_lat++;
            if (we_w != LO) width_bad++;
        end
        prev_we = nand_we_n;
        if (!nand_re_n) begin
            if (prev_re) re_w = 1; else re_w++;
        end else if (!prev_re) begin
            n_rd++;
            if (re_w != LO) width_bad++;
        end
        prev_re = nand_re_n;
        nand_dq_in = 8'h5A ^ n_rd[7:0];
        if (irq) begin
            irq_cnt++;
            if (reg_addr == 3'd0 && reg_rdata[31]) irq_busy_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit ie, input logic [4:0] m, input logic [7:0] op,
                                       input logic [15:0] fl, input logic [11:0] n);
        return 32'h8000_0000 | (32'(ie) << 30) | (32'(m) << 24) | (32'(op) << 16) | 32'(fl) | 32'(n);
    endfunction

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 3'd0;
    endtask

    task automatic issue(input logic [31:0] c);
        reg_wr(3'd0, 32'h7FFF_FFFF);
        reg_wr(3'd0, 32'd0);
        reg_wr(3'd0, c);
    endtask

    task automatic wait_idle(input string req);
        bit ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            if (!reg_rdata[31]) begin ok = 1'b1; break; end
        end
        chk(ok, req, 32'(ok), 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_rd(3'd0, d);
        chk(d[31] == 1'b0, "R1 busy", 32'(d[31]), 32'd0);
        chk({nand_ce_n, nand_we_n, nand_re_n, irq} == 4'b1110, "R1 pins",
            32'({nand_ce_n, nand_we_n, nand_re_n, irq}), 32'hE);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        reg_wr(3'd1, 32'h0000_1234); reg_wr(3'd2, 32'h00AB_CDEF);
        reg_wr(3'd3, 32'h10);        reg_wr(3'd4, 32'h80);
        reg_rd(3'd1, d); chk(d == 32'h1234,   "R12 column", d, 32'h1234);
        reg_rd(3'd2, d); chk(d == 32'hABCDEF, "R12 page",   d, 32'hABCDEF);
        reg_rd(3'd3, d); chk(d == 32'h10,     "R12 dbase",  d, 32'h10);
        reg_rd(3'd4, d); chk(d == 32'h80,     "R12 sbase",  d, 32'h80);
    endtask

    task automatic t_read_id();
        int b = n_lat, r = n_rd;
        logic [31:0] d, c;
        c = mk(1'b0, 5'h01, 8'h90, 16'h2000, 12'd4);
        issue(c);
        wait_idle("R2 id completes");
        chk(n_lat - b == 2, "R3 id latch count", 32'(n_lat - b), 32'd2);
        chk(lat_kind[b] == 2'd1 && lat_val[b] == 8'h90, "R2 id opcode", 32'(lat_val[b]), 32'h90);
        chk(lat_kind[b+1] == 2'd2 && lat_val[b+1] == 8'h34, "R3 id addr byte", 32'(lat_val[b+1]), 32'h34);
        chk(n_rd - r == 4, "R6 id read strobes", 32'(n_rd - r), 32'd4);
        for (int k = 0; k < 4; k++)
            chk(mem[8'h10 + k] == (8'h5A ^ 8'(r + k)), "R6 id byte", 32'(mem[8'h10 + k]), 32'(8'h5A ^ 8'(r + k)));
        reg_rd(3'd0, d);
        chk(d == (c & 32'h7FFF_FFFF), "R12 cmd readback", d, c & 32'h7FFF_FFFF);
    endtask

    task automatic t_page_read();
        int b, r, q;
        logic [7:0] ex [0:5];
        ex[0] = 8'h00; ex[1] = 8'h04; ex[2] = 8'h02; ex[3] = 8'h23; ex[4] = 8'h01; ex[5] = 8'h00;
        reg_wr(3'd1, 32'h0204); reg_wr(3'd2, 32'h000123);
        b = n_lat;
        issue(mk(1'b0, 5'h1F, 8'h00, 16'h0000, 12'd0));
        wait_idle("R9 setup completes");
        chk(n_lat - b == 6, "R3 full mask count", 32'(n_lat - b), 32'd6);
        for (int k = 0; k < 6; k++)
            chk(lat_val[b+k] == ex[k] && lat_kind[b+k] == ((k == 0) ? 2'd1 : 2'd2),
                "R3 address order", 32'(lat_val[b+k]), 32'(ex[k]));
        nand_rb = 1'b0;
        b = n_lat; r = n_rd; q = irq_cnt;
        issue(mk(1'b1, 5'h00, 8'h30, 16'hB000, 12'd20));
        repeat (30) @(negedge clk);
        #1;
        chk(n_rd == r, "R5 held while rb low", 32'(n_rd - r), 32'd0);
        chk(reg_rdata[31] == 1'b1, "R2 busy during wait", 32'(reg_rdata[31]), 32'd1);
        nand_rb = 1'b1;
        wait_idle("R5 resumes after rb");
        repeat (3) @(negedge clk);
        chk(n_lat - b == 1 && lat_val[b] == 8'h30, "R2 confirm opcode", 32'(lat_val[b]), 32'h30);
        chk(n_rd - r == 20, "R6 page byte count", 32'(n_rd - r), 32'd20);
        for (int k = 0; k < 16; k++)
            chk(mem[8'h10 + k] == (8'h5A ^ 8'(r + k)), "R8 data area", 32'(mem[8'h10 + k]), 32'(8'h5A ^ 8'(r + k)));
        for (int k = 16; k < 20; k++)
            chk(mem[8'h80 + k - 16] == (8'h5A ^ 8'(r + k)), "R8 spare area", 32'(mem[8'h80 + k - 16]), 32'(8'h5A ^ 8'(r + k)));
        chk(irq_cnt - q == 1, "R10 one pulse", 32'(irq_cnt - q), 32'd1);
        chk(irq_busy_bad == 0, "R10 pulse after busy", 32'(irq_busy_bad), 32'd0);
    endtask

    task automatic t_no_spare();
        int r;
        for (int k = 0; k < 4; k++) mem[8'h80 + k] = 8'hEE;
        reg_wr(3'd3, 32'h20);
        r = n_rd;
        issue(mk(1'b0, 5'h00, 8'h00, 16'h2000, 12'd18));
        wait_idle("R8 contiguous completes");
        for (int k = 16; k < 18; k++)
            chk(mem[8'h20 + k] == (8'h5A ^ 8'(r + k)), "R8 contiguous", 32'(mem[8'h20 + k]), 32'(8'h5A ^ 8'(r + k)));
        chk(mem[8'h80] == 8'hEE, "R8 spare untouched", 32'(mem[8'h80]), 32'hEE);
    endtask

    task automatic t_write();
        int b, r, q;
        for (int k = 0; k < 5; k++) mem[8'h40 + k] = 8'hC3 + 8'(7 * k);
        reg_wr(3'd3, 32'h40);
        nand_rb = 1'b0;
        b = n_lat; r = n_rd; q = irq_cnt;
        issue(mk(1'b0, 5'h04, 8'h80, 16'h4000, 12'd5));
        wait_idle("R5 rb ignored without flag");
        repeat (3) @(negedge clk);
        nand_rb = 1'b1;
        chk(n_lat - b == 7, "R7 strobe count", 32'(n_lat - b), 32'd7);
        chk(lat_val[b] == 8'h80 && lat_val[b+1] == 8'h23, "R3 row byte", 32'(lat_val[b+1]), 32'h23);
        for (int k = 0; k < 5; k++)
            chk(lat_kind[b+2+k] == 2'd0 && lat_val[b+2+k] == 8'hC3 + 8'(7 * k), "R7 data out",
                32'(lat_val[b+2+k]), 32'(8'hC3 + 8'(7 * k)));
        chk(n_rd == r, "R7 no read strobes", 32'(n_rd - r), 32'd0);
        chk(irq_cnt == q, "R10 no pulse when disabled", 32'(irq_cnt - q), 32'd0);
    endtask

    task automatic t_erase();
        int b;
        reg_wr(3'd2, 32'h5A6B7C);
        b = n_lat;
        issue(mk(1'b0, 5'h1C, 8'h60, 16'h0000, 12'd0));
        wait_idle("R9 erase setup");
        chk(n_lat - b == 4, "R3 row-only mask", 32'(n_lat - b), 32'd4);
        chk(lat_val[b+1] == 8'h7C && lat_val[b+2] == 8'h6B && lat_val[b+3] == 8'h5A,
            "R3 row bytes", {8'd0, lat_val[b+1], lat_val[b+2], lat_val[b+3]}, 32'h7C6B5A);
        b = n_lat;
        issue(mk(1'b0, 5'h00, 8'hD0, 16'h8000, 12'd0));
        wait_idle("R9 confirm no data");
        chk(n_lat - b == 1 && lat_val[b] == 8'hD0, "R9 only opcode", 32'(n_lat - b), 32'd1);
        chk(width_bad == 0, "R4 strobe low width", 32'(width_bad), 32'd0);
        chk(stable_bad == 0, "R4 lines stable", 32'(stable_bad), 32'd0);
    endtask

    task automatic t_abort();
        int r, q;
        logic [31:0] d, c;
        reg_wr(3'd3, 32'h10);
        c = mk(1'b1, 5'h00, 8'h00, 16'h2000, 12'd12);
        q = irq_cnt;
        issue(c);
        repeat (6) @(negedge clk);
        reg_wr(3'd0, mk(1'b0, 5'h1F, 8'hFF, 16'h0000, 12'd0));
        reg_rd(3'd0, d);
        chk(d == c, "R11 busy write ignored", d, c);
        reg_wr(3'd0, 32'h7FFF_FFFF);
        #1;
        chk(reg_rdata[31] == 1'b0 && nand_ce_n == 1'b1, "R11 abort idles",
            32'({reg_rdata[31], nand_ce_n}), 32'd1);
        @(negedge clk);
        r = n_rd;
        repeat (20) @(negedge clk);
        chk(n_rd == r, "R11 no strobes after abort", 32'(n_rd - r), 32'd0);
        chk(irq_cnt == q, "R11 no irq on abort", 32'(irq_cnt - q), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_read_id();
        t_page_read();
        t_no_spare();
        t_write();
        t_erase();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule